// File: doc/BRIEF.md
# CAN Transmit/Receive Message Queue Pair

This block sits between a software register port and a CAN protocol engine. It holds two four-deep message queues. Frames flow out of one to the engine and in from the engine through the other. Each stored frame has three parts: a 32-bit identifier word, a 4-bit length code and 64 bits of payload. Software never addresses the queue slots directly. On the transmit side it fills a single staging window and then writes any value to the transmit advance register; that write turns the window into a new queued frame. On the receive side it reads the oldest stored frame through a read-only window and writes any value to the receive advance register to drop that frame.

The engine side uses a plain handshake. The block offers the oldest unsent frame with `tx_valid`, and the engine pulses `tx_done` once that frame has gone out. The engine delivers a received frame with a one-cycle `rx_push`. Both directions share one interrupt status register. Each direction sets its own flag there, and software clears a flag by writing 0 to its bit. A frame that arrives while the receive queue is full is lost, and the block reports the loss with a one-cycle `rx_overrun` pulse.

Top module: `can_msg_queue`

## Requirements
- R1: After reset, the transmit control register reads 0x0 and the receive control register reads 0x80. The status register reads 0 and `tx_valid` and `rx_overrun` are low. The receive window words read 0. The register map is: 0 TX window ID, 1 TX window length (bits 3:0), 2 TX payload bytes 0-3 (byte 0 in bits 7:0), 3 TX payload bytes 4-7, 4..7 the same four words for the RX window, 8 TX control, 9 TX advance, 10 RX control, 11 RX advance, 12 status.
- R2: A write of any value to address 9 appends the TX window as a new frame. Transmit control bits 3:1 give the number of unsent frames and bit 0 holds the enable. Frames are presented on `tx_id`/`tx_dlc`/`tx_data` in the order they were committed.
- R3: A commit while four frames are unsent is ignored. The count stays 4 and the queued frames are unchanged.
- R4: `tx_valid` is high only while TX is enabled and a frame is queued. A `tx_done` pulse while `tx_valid` is high retires the oldest frame and sets status bit 3. A `tx_done` pulse while TX is disabled has no effect.
- R5: An `rx_push` while RX is enabled and not full stores the frame and clears receive control bit 7. It also sets status bit 4, and the RX window then shows the oldest stored frame.
- R6: An `rx_push` while RX is disabled (receive control bit 0 = 0) is dropped. The queue stays empty and status bit 4 stays 0.
- R7: A write of any value to address 11 drops the oldest received frame. When the queue is empty, that write has no effect, and a later push is stored and shown normally.
- R8: An `rx_push` into a full, enabled receive queue drops the frame. `rx_overrun` goes high for exactly the following cycle and the stored frames are unchanged.
- R9: A write to the status register clears each flag whose bit (3 or 4) is written 0 and keeps each flag written 1. A setting event in the same cycle wins over the clear.
- R10: The identifier word passes through both queues unchanged, including bit 31 (extended frame), bit 30 (remote frame) and the identifier fields in bits 28:18 and 28:0.
- R11: The length field holds 4 bits. Writing 0xFF to address 1 reads back 0xF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_addr | input | 4 | Register address |
| sw_we | input | 1 | Register write strobe |
| sw_wdata | input | 32 | Register write data |
| sw_rdata | output | 32 | Register read data (combinational) |
| tx_valid | output | 1 | Oldest unsent frame is offered |
| tx_id | output | 32 | Offered frame identifier word |
| tx_dlc | output | 4 | Offered frame length code |
| tx_data | output | 64 | Offered frame payload |
| tx_done | input | 1 | Engine finished sending the offered frame |
| rx_push | input | 1 | Engine delivers a received frame |
| rx_id | input | 32 | Received identifier word |
| rx_dlc | input | 4 | Received length code |
| rx_data | input | 64 | Received payload |
| rx_overrun | output | 1 | Pulse: received frame lost on full queue |

## Verification
Every register write and every engine pulse is captured on the rising edge on which it is sampled. Counts, windows, `tx_valid` and status flags therefore show the new state right after that edge, and reads are combinational. `rx_overrun` is registered, so it is high during the one cycle after the rejected push and low after the next edge. The bench drives inputs at the falling edge, lets one rising edge pass and compares on the next falling edge. Each result is thus checked in the exact cycle it is due, and the overrun pulse is also checked for being low one cycle later.

// File: rtl/can_mq_pkg.sv
package can_mq_pkg;

  localparam int unsigned ID_W   = 32;
  localparam int unsigned DLC_W  = 4;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned ADDR_W = 4;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
  } frame_t;

  localparam logic [ADDR_W-1:0] A_TXID  = 4'd0;
  localparam logic [ADDR_W-1:0] A_TXDLC = 4'd1;
  localparam logic [ADDR_W-1:0] A_TXDLO = 4'd2;
  localparam logic [ADDR_W-1:0] A_TXDHI = 4'd3;
  localparam logic [ADDR_W-1:0] A_RXID  = 4'd4;
  localparam logic [ADDR_W-1:0] A_RXDLC = 4'd5;
  localparam logic [ADDR_W-1:0] A_RXDLO = 4'd6;
  localparam logic [ADDR_W-1:0] A_RXDHI = 4'd7;
  localparam logic [ADDR_W-1:0] A_TXCTL = 4'd8;
  localparam logic [ADDR_W-1:0] A_TXADV = 4'd9;
  localparam logic [ADDR_W-1:0] A_RXCTL = 4'd10;
  localparam logic [ADDR_W-1:0] A_RXADV = 4'd11;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd12;

  localparam int unsigned STAT_TX_BIT  = 3;
  localparam int unsigned STAT_RX_BIT  = 4;
  localparam int unsigned RX_EMPTY_BIT = 7;

endpackage

// File: rtl/mq_queue.sv
module mq_queue
  import can_mq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  frame_t           din,
  output frame_t           dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0]    LAST_IDX = PW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  frame_t           slots [DEPTH];
  logic [PW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt_q == FULL_CNT);
  assign empty = (cnt_q == '0);
  assign count = cnt_q;
  assign dout  = slots[rd_q];

  always_comb begin
    do_push = push & ~full;
    do_pop  = pop & ~empty;
    wr_d    = do_push ? nxt(wr_q) : wr_q;
    rd_d    = do_pop  ? nxt(rd_q) : rd_q;
    cnt_d   = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slots[wr_q] <= din;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT); // R3
  AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (cnt_q == $past(cnt_q))); // R3
  AST_EMPTY_NO_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty); // R7

endmodule

// File: rtl/mq_tx_window.sv
module mq_tx_window
  import can_mq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output frame_t            win
);

  frame_t win_q, win_d;

  always_comb begin
    win_d = win_q;
    if (we) begin
      unique case (addr)
        A_TXID:  win_d.id          = wdata;
        A_TXDLC: win_d.dlc         = wdata[DLC_W-1:0];
        A_TXDLO: win_d.data[31:0]  = wdata;
        A_TXDHI: win_d.data[63:32] = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end

  assign win = win_q;

endmodule

// File: rtl/mq_status.sv
module mq_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] keep_mask,
  input  logic       tx_evt,
  input  logic       rx_evt,
  output logic [1:0] flags
);

  logic [1:0] fl_q, fl_d;

  always_comb begin
    fl_d = fl_q;
    if (wr_en) fl_d = fl_d & keep_mask;
    if (tx_evt) fl_d[0] = 1'b1;
    if (rx_evt) fl_d[1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fl_q <= '0;
    else        fl_q <= fl_d;
  end

  assign flags = fl_q;

  AST_TX_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt |=> flags[0]); // R4
  AST_RX_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt |=> flags[1]); // R5
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !tx_evt && !rx_evt) |=> $stable(flags)); // R9

endmodule

// File: rtl/can_msg_queue.sv
module can_msg_queue
  import can_mq_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic              sw_we,
  input  logic [31:0]       sw_wdata,
  output logic [31:0]       sw_rdata,
  output logic              tx_valid,
  output logic [ID_W-1:0]   tx_id,
  output logic [DLC_W-1:0]  tx_dlc,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_done,
  input  logic              rx_push,
  input  logic [ID_W-1:0]   rx_id,
  input  logic [DLC_W-1:0]  rx_dlc,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_overrun
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic             tx_en_q, tx_en_d, rx_en_q, rx_en_d;
  logic             ovr_q, ovr_d;
  logic             tx_commit, tx_pop, rx_store, rx_pop;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic [1:0]       flags;
  frame_t           tx_win, tx_head, rx_head, rx_in, rx_view;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  always_comb begin
    tx_commit = sw_we && (sw_addr == A_TXADV);
    rx_pop    = sw_we && (sw_addr == A_RXADV);
    tx_valid  = tx_en_q & ~tx_empty;
    tx_pop    = tx_done & tx_valid;
    rx_store  = rx_push & rx_en_q;
    tx_en_d   = (sw_we && sw_addr == A_TXCTL) ? sw_wdata[0] : tx_en_q;
    rx_en_d   = (sw_we && sw_addr == A_RXCTL) ? sw_wdata[0] : rx_en_q;
    ovr_d     = rx_store & rx_full;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      tx_en_q <= tx_en_d;
      rx_en_q <= rx_en_d;
      ovr_q   <= ovr_d;
    end
  end

  assign rx_overrun = ovr_q;

  mq_tx_window u_txwin (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (sw_we),
    .addr  (sw_addr),
    .wdata (sw_wdata),
    .win   (tx_win)
  );

  mq_queue #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_txq (
    .clk   (clk),
    .rst_n (rst_int_n),
    .push  (tx_commit),
    .pop   (tx_pop),
    .din   (tx_win),
    .dout  (tx_head),
    .count (tx_cnt),
    .full  (tx_full),
    .empty (tx_empty)
  );

  assign rx_in = '{id: rx_id, dlc: rx_dlc, data: rx_data};

  mq_queue #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rxq (
    .clk   (clk),
    .rst_n (rst_int_n),
    .push  (rx_store),
    .pop   (rx_pop),
    .din   (rx_in),
    .dout  (rx_head),
    .count (rx_cnt),
    .full  (rx_full),
    .empty (rx_empty)
  );

  mq_status u_stat (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (sw_we && (sw_addr == A_STAT)),
    .keep_mask ({sw_wdata[STAT_RX_BIT], sw_wdata[STAT_TX_BIT]}),
    .tx_evt    (tx_pop),
    .rx_evt    (rx_store & ~rx_full),
    .flags     (flags)
  );

  assign tx_id   = tx_head.id;
  assign tx_dlc  = tx_head.dlc;
  assign tx_data = tx_head.data;
  assign rx_view = rx_empty ? '0 : rx_head;

  always_comb begin
    sw_rdata = '0;
    unique case (sw_addr)
      A_TXID:  sw_rdata = tx_win.id;
      A_TXDLC: sw_rdata = 32'(tx_win.dlc);
      A_TXDLO: sw_rdata = tx_win.data[31:0];
      A_TXDHI: sw_rdata = tx_win.data[63:32];
      A_RXID:  sw_rdata = rx_view.id;
      A_RXDLC: sw_rdata = 32'(rx_view.dlc);
      A_RXDLO: sw_rdata = rx_view.data[31:0];
      A_RXDHI: sw_rdata = rx_view.data[63:32];
      A_TXCTL: sw_rdata = (32'(tx_cnt) << 1) | 32'(tx_en_q);
      A_RXCTL: sw_rdata = (32'(rx_empty) << RX_EMPTY_BIT) | 32'(rx_en_q);
      A_STAT:  sw_rdata = (32'(flags[1]) << STAT_RX_BIT) | (32'(flags[0]) << STAT_TX_BIT);
      default: sw_rdata = '0;
    endcase
  end

  AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_int_n)
    rx_overrun |-> $past(rx_full)); // R8
  AST_TXV_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_int_n)
    tx_valid |-> (tx_en_q && tx_cnt != '0)); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tx_done && !tx_valid && !tx_commit) |=> (tx_cnt == $past(tx_cnt))); // R4
  AST_RX_OFF_DROP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rx_push && !rx_en_q && !rx_pop) |=> (rx_cnt == $past(rx_cnt))); // R6

endmodule

// File: tb/can_msg_queue_test.sv
module can_msg_queue_test;

  localparam logic [3:0] TXID = 4'd0, TXDLC = 4'd1, TXDLO = 4'd2, TXDHI = 4'd3;
  localparam logic [3:0] RXID = 4'd4, RXDLC = 4'd5, RXDLO = 4'd6, RXDHI = 4'd7;
  localparam logic [3:0] TXCTL = 4'd8, TXADV = 4'd9, RXCTL = 4'd10, RXADV = 4'd11, STAT = 4'd12;

  localparam int NV = 25;
  // {we, addr, wdata, expected read}
  localparam logic [68:0] VEC [NV] = '{
    {1'b1, TXCTL, 32'h1,          32'h0},        // R2 enable tx
    {1'b1, RXCTL, 32'h1,          32'h0},        // R5 enable rx
    {1'b0, TXCTL, 32'h0,          32'h1},        // R2
    {1'b0, RXCTL, 32'h0,          32'h81},       // R5 empty, enabled
    {1'b1, TXID,  32'h9ABCDEF0,   32'h0},        // R10 extended id
    {1'b1, TXDLC, 32'hFF,         32'h0},
    {1'b0, TXDLC, 32'h0,          32'hF},        // R11
    {1'b1, TXDLC, 32'h8,          32'h0},
    {1'b1, TXDLO, 32'h03020100,   32'h0},
    {1'b1, TXDHI, 32'h07060504,   32'h0},
    {1'b0, TXID,  32'h0,          32'h9ABCDEF0}, // R10
    {1'b1, TXADV, 32'h5A,         32'h0},        // R2 commit, any value
    {1'b0, TXCTL, 32'h0,          32'h3},        // R2 one unsent
    {1'b1, TXID,  32'h448C0000,   32'h0},        // R10 remote, std id
    {1'b1, TXDLC, 32'h0,          32'h0},
    {1'b1, TXADV, 32'hFF,         32'h0},
    {1'b1, TXID,  32'h00000001,   32'h0},
    {1'b1, TXADV, 32'h0,          32'h0},
    {1'b1, TXID,  32'h1FFFFFFF,   32'h0},
    {1'b1, TXADV, 32'hFF,         32'h0},
    {1'b0, TXCTL, 32'h0,          32'h9},        // R2 four unsent
    {1'b1, TXID,  32'h55555555,   32'h0},
    {1'b1, TXADV, 32'hFF,         32'h0},        // R3 commit on full
    {1'b0, TXCTL, 32'h0,          32'h9},        // R3 count held
    {1'b0, STAT,  32'h0,          32'h0}         // R4 commits raise no flag
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  sw_addr;
  logic        sw_we;
  logic [31:0] sw_wdata, sw_rdata;
  logic        tx_valid, tx_done, rx_push, rx_overrun;
  logic [31:0] tx_id, rx_id;
  logic [3:0]  tx_dlc, rx_dlc;
  logic [63:0] tx_data, rx_data;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  can_msg_queue uut (
    .clk(clk), .rst_n(rst_n), .sw_addr(sw_addr), .sw_we(sw_we),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .tx_valid(tx_valid),
    .tx_id(tx_id), .tx_dlc(tx_dlc), .tx_data(tx_data), .tx_done(tx_done),
    .rx_push(rx_push), .rx_id(rx_id), .rx_dlc(rx_dlc), .rx_data(rx_data),
    .rx_overrun(rx_overrun)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // drive at falling edge, let a rising edge pass, return at the next falling edge
  task automatic sw_write(input logic [3:0] a, input logic [31:0] d);
    sw_addr = a; sw_we = 1'b1; sw_wdata = d;
    @(posedge clk); @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic sw_check(input string req, input logic [3:0] a, input logic [31:0] exp);
    sw_addr = a; #1;
    chk(req, 64'(sw_rdata), 64'(exp));
  endtask

  task automatic engine_done();
    tx_done = 1'b1;
    @(posedge clk); @(negedge clk);
    tx_done = 1'b0;
  endtask

  task automatic engine_push(input logic [31:0] id, input logic [3:0] dlc, input logic [63:0] d);
    rx_push = 1'b1; rx_id = id; rx_dlc = dlc; rx_data = d;
    @(posedge clk); @(negedge clk);
    rx_push = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sw_addr = '0; sw_we = 1'b0; sw_wdata = '0;
    tx_done = 1'b0; rx_push = 1'b0; rx_id = '0; rx_dlc = '0; rx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    sw_check("R1 txctl", TXCTL, 32'h0);
    sw_check("R1 rxctl", RXCTL, 32'h80);
    sw_check("R1 stat", STAT, 32'h0);
    sw_check("R1 rx window", RXID, 32'h0);
    chk("R1 tx_valid", 64'(tx_valid), 64'd0);
    chk("R1 rx_overrun", 64'(rx_overrun), 64'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][68]) sw_write(VEC[i][67:64], VEC[i][63:32]);
      else sw_check($sformatf("R%0d vec%0d", (VEC[i][67:64] == TXCTL) ? 2 : 11, i),
                    VEC[i][67:64], VEC[i][31:0]);
    end

    // R2 FIFO order at engine side, R10 word unchanged
    chk("R2 tx_valid", 64'(tx_valid), 64'd1);
    chk("R10 tx_id first", 64'(tx_id), 64'h9ABCDEF0);
    chk("R2 tx_dlc first", 64'(tx_dlc), 64'd8);
    chk("R2 tx_data first", tx_data, 64'h0706050403020100);

    // R4 disabled: no offer, done ignored
    sw_write(TXCTL, 32'h0);
    chk("R4 tx_valid off", 64'(tx_valid), 64'd0);
    engine_done();
    sw_check("R4 done while off", TXCTL, 32'h8);
    sw_check("R4 no flag while off", STAT, 32'h0);
    sw_write(TXCTL, 32'h1);

    engine_done();
    chk("R10 tx_id second", 64'(tx_id), 64'h448C0000);
    sw_check("R4 count after done", TXCTL, 32'h7);
    sw_check("R4 tx flag", STAT, 32'h08);

    // R9 write-0-to-clear
    sw_write(STAT, 32'h10);
    sw_check("R9 clear tx flag", STAT, 32'h0);
    sw_addr = STAT; sw_we = 1'b1; sw_wdata = 32'h0; tx_done = 1'b1;
    @(posedge clk); @(negedge clk);
    sw_we = 1'b0; tx_done = 1'b0;
    sw_check("R9 set beats clear", STAT, 32'h08);
    chk("R3 third frame", 64'(tx_id), 64'h1);
    engine_done();
    chk("R3 fourth frame", 64'(tx_id), 64'h1FFFFFFF);
    engine_done();
    chk("R4 drained", 64'(tx_valid), 64'd0);
    sw_check("R4 count zero", TXCTL, 32'h1);
    engine_done();
    sw_check("R4 done on empty", TXCTL, 32'h1);
    sw_write(STAT, 32'h0);

    // R6 disabled receive
    sw_write(RXCTL, 32'h0);
    engine_push(32'h77, 4'd1, 64'h0);
    sw_check("R6 rx dropped", RXCTL, 32'h80);
    sw_check("R6 no rx flag", STAT, 32'h0);
    sw_write(RXCTL, 32'h1);

    // R5 store four
    for (int k = 0; k < 4; k++)
      engine_push(32'h100 + 32'(k), 4'(k + 1), {32'hC0 + 32'(k), 32'hD0 + 32'(k)});
    sw_check("R5 not empty", RXCTL, 32'h01);
    sw_check("R5 rx flag", STAT, 32'h10);
    sw_check("R5 oldest id", RXID, 32'h100);
    sw_check("R5 oldest dlc", RXDLC, 32'h1);
    sw_check("R5 oldest lo", RXDLO, 32'hD0);
    sw_check("R5 oldest hi", RXDHI, 32'hC0);

    // R8 overrun
    engine_push(32'h999, 4'd2, 64'h0);
    chk("R8 overrun pulse", 64'(rx_overrun), 64'd1);
    @(posedge clk); @(negedge clk);
    chk("R8 overrun single", 64'(rx_overrun), 64'd0);
    sw_check("R8 head kept", RXID, 32'h100);

    // R7 pops
    sw_write(RXADV, 32'h3C);
    sw_check("R7 next id", RXID, 32'h101);
    sw_check("R7 next dlc", RXDLC, 32'h2);
    sw_write(RXADV, 32'hFF);
    sw_write(RXADV, 32'hFF);
    sw_check("R8 last kept", RXID, 32'h103);
    sw_write(RXADV, 32'hFF);
    sw_check("R7 empty", RXCTL, 32'h81);
    sw_check("R7 window zero", RXID, 32'h0);
    sw_write(RXADV, 32'hFF);
    sw_check("R7 pop on empty", RXCTL, 32'h81);
    engine_push(32'hC1234567, 4'd3, 64'h1122334455667788);
    sw_check("R10 rx id", RXID, 32'hC1234567);
    sw_check("R7 rx after empty pop", RXCTL, 32'h01);
    sw_check("R10 rx hi", RXDHI, 32'h11223344);

    finish_run();
  end

endmodule